// File: doc/BRIEF.md
# Indirect Multi-Memory Access Controller

This block gives a control bus indirect access to four internal memories, called here the C, E, H and vector memories. Software stages a 10-bit word address, a 40-bit word made of four 10-bit fields, and a 9-bit control value. The controller watches the control value for an enable bit together with exactly one newly raised operation bit. It then performs one single-word write or read on the memory that bit selects. Read results are captured into a read-back word that holds until the next read completes.

The C, E and H memories are fast and finish an access at the clock edge that accepts it. The vector memory is modelled as a slow dynamic array. Its access completes a fixed `VLAT` cycles later, and no new operation is accepted while it is in flight. The expected software sequence raises the enable bit alone, then enable plus one operation bit, then enable alone, and finally clears the value. After the clear, the controller is free again well within four cycles.

Top module: `mram_indirect_ctrl`

## Requirements
- R1: After reset, `rd_word_o` is all zeros.
- R2: Field k of a word occupies bits [10k+9:10k] of both `wr_word_i` and `rd_word_o`, for k = 0 to 3. A word written and later read back returns in the same positions.
- R3: Control bit 8 is the enable. Bits 0 to 3 request a write to the C, E, H and vector memory respectively. Bits 4 to 7 request a read from the same four memories in the same order.
- R4: Operation bits raised while bit 8 is low start no access. Neither the memory nor `rd_word_o` changes.
- R5: When two or more of bits 0 to 7 are set at once, no access is performed.
- R6: An operation starts only in the cycle its select bit rises from 0 to 1. Holding the bit set does not repeat it, even when the address or data inputs change.
- R7: A C, E or H access is performed at the clock edge that samples the rising select bit. Read data appears on `rd_word_o` right after that edge.
- R8: A vector-memory access takes its address and data at the accepting edge. It completes exactly `VLAT` (default 4, at most 6) edges later, and read data appears on `rd_word_o` right after that completion edge.
- R9: While a vector-memory access is in flight, any other operation request is ignored. Requests are accepted again from the edge after completion.
- R10: The four memories are separate stores. The same address holds independent words in each memory.
- R11: The memories hold `DEPTH` (default 256) words each. Only the low log2(`DEPTH`) address bits select the word, so higher address bits alias.
- R12: `rd_word_o` changes only when a read completes. Writes and ignored requests leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ram_addr_i | input | 10 | Word address register value |
| wr_word_i | input | 40 | Four 10-bit write-data fields |
| ctrl_i | input | 9 | Control value: enable in bit 8, read selects in bits 7..4, write selects in bits 3..0 |
| rd_word_o | output | 40 | Four 10-bit read-back fields |

## Verification
The main function is driven through the normal four-step control sequence. This covers writes and reads on every memory at a shared address, which separates a wrong select decode or field order from a correct one. Malformed patterns come next: operation bits without enable, several operation bits at once, select bits held while address and data move, and requests raised during a vector access. These show whether acceptance is gated by enable, one-hot decoding, edge detection and the in-flight window. Reads at an address plus `DEPTH`, and cycle-exact sampling around the vector completion edge, tell aliasing and the fixed slow latency apart from an off-by-one.

// File: rtl/mram_pkg.sv
package mram_pkg;
  localparam int NRAM    = 4;
  localparam int FIELD_W = 10;
  localparam int NFIELD  = 4;
  localparam int WORD_W  = FIELD_W * NFIELD;
  localparam int OP_W    = 2 * NRAM;

  typedef enum logic [1:0] {
    RAM_C = 2'd0,
    RAM_E = 2'd1,
    RAM_H = 2'd2,
    RAM_V = 2'd3
  } ram_id_t;

  // bit 8 enable, bits 7..4 read selects, bits 3..0 write selects
  typedef struct packed {
    logic            en;
    logic [NRAM-1:0] rd;
    logic [NRAM-1:0] wr;
  } ctrl_t;
endpackage

// File: rtl/mram_rst_sync.sv
module mram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s = sync_q[1];
endmodule

// File: rtl/mram_decode.sv
module mram_decode
  import mram_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ctrl_t   ctrl,
  input  logic    busy,
  output logic    launch,
  output logic    is_write,
  output ram_id_t ram_id
);
  logic [OP_W-1:0] op;
  logic [OP_W-1:0] prev_q, prev_d;
  logic [NRAM-1:0] sel;
  logic            single;
  logic            rising;

  always_comb begin
    op     = {ctrl.rd, ctrl.wr};
    single = ($countones(op) == 1);
    rising = |(op & ~prev_q);
    launch = ctrl.en && single && rising && !busy;
    is_write = |ctrl.wr;
    sel    = is_write ? ctrl.wr : ctrl.rd;
    ram_id = RAM_C;
    for (int i = 0; i < NRAM; i++) begin
      if (sel[i]) ram_id = ram_id_t'(i);
    end
    prev_d = op;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/mram_vseq.sv
module mram_vseq
  import mram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int VLAT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [WORD_W-1:0] start_word,
  output logic              busy,
  output logic              fire,
  output logic              f_write,
  output logic [ADDR_W-1:0] f_addr,
  output logic [WORD_W-1:0] f_word
);
  localparam int CNT_W = $clog2(VLAT + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(VLAT);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = CNT_LOAD;
    else if (cnt_q != '0)   cnt_d = cnt_q - CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // operands held from the accepting edge until completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_write <= 1'b0;
      f_addr  <= '0;
      f_word  <= '0;
    end else if (start) begin
      f_write <= start_write;
      f_addr  <= start_addr;
      f_word  <= start_word;
    end
  end

  assign busy = (cnt_q != '0);
  assign fire = (cnt_q == CNT_ONE);
endmodule

// File: rtl/mram_bank.sv
module mram_bank
  import mram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic [NRAM-1:0]   we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wword,
  input  logic [ADDR_W-1:0] raddr,
  input  ram_id_t           rsel,
  output logic [WORD_W-1:0] rword
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] rd_each [NRAM];
  logic [IDX_W-1:0]  widx, ridx;

  assign widx = waddr[IDX_W-1:0];
  assign ridx = raddr[IDX_W-1:0];

  for (genvar g = 0; g < NRAM; g++) begin : g_ram
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) mem[widx] <= wword;
    end

    assign rd_each[g] = mem[ridx];
  end

  assign rword = rd_each[rsel];
endmodule

// File: rtl/mram_indirect_ctrl.sv
module mram_indirect_ctrl
  import mram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DEPTH  = 256,
  parameter int VLAT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [9:0]        ram_addr_i,
  input  logic [39:0]       wr_word_i,
  input  logic [8:0]        ctrl_i,
  output logic [39:0]       rd_word_o
);
  logic              rst_s;
  ctrl_t             ctrl;
  logic              launch, is_write;
  ram_id_t           ram_id;
  logic              busy, vstart, vfire, f_write;
  logic [ADDR_W-1:0] f_addr, waddr, raddr;
  logic [WORD_W-1:0] f_word, wword, rword;
  logic [NRAM-1:0]   ram_we;
  ram_id_t           rsel;
  logic              fast_go, rd_done;
  logic [WORD_W-1:0] rd_q, rd_d;

  assign ctrl = ctrl_t'(ctrl_i);

  mram_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  mram_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_s),
    .ctrl     (ctrl),
    .busy     (busy),
    .launch   (launch),
    .is_write (is_write),
    .ram_id   (ram_id)
  );

  assign vstart  = launch && (ram_id == RAM_V);
  assign fast_go = launch && (ram_id != RAM_V);

  mram_vseq #(.ADDR_W(ADDR_W), .VLAT(VLAT)) u_vseq (
    .clk         (clk),
    .rst_n       (rst_s),
    .start       (vstart),
    .start_write (is_write),
    .start_addr  (ram_addr_i),
    .start_word  (wr_word_i),
    .busy        (busy),
    .fire        (vfire),
    .f_write     (f_write),
    .f_addr      (f_addr),
    .f_word      (f_word)
  );

  always_comb begin
    ram_we = '0;
    for (int i = 0; i < NRAM; i++) begin
      if (ram_id_t'(i) == RAM_V) ram_we[i] = vfire && f_write;
      else                       ram_we[i] = fast_go && is_write && (ram_id == ram_id_t'(i));
    end
    waddr   = vfire ? f_addr : ram_addr_i;
    wword   = vfire ? f_word : wr_word_i;
    raddr   = vfire ? f_addr : ram_addr_i;
    rsel    = vfire ? RAM_V  : ram_id;
    rd_done = (fast_go && !is_write) || (vfire && !f_write);
    rd_d    = rd_done ? rword : rd_q;
  end

  mram_bank #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_bank (
    .clk   (clk),
    .we    (ram_we),
    .waddr (waddr),
    .wword (wword),
    .raddr (raddr),
    .rsel  (rsel),
    .rword (rword)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_word_o = rd_q;
endmodule

// File: rtl/mram_ctrl_chk.sv
module mram_ctrl_chk (
  input  logic        clk,
  input  logic        rst_s,
  input  logic [8:0]  ctrl_i,
  input  logic        launch,
  input  logic        busy,
  input  logic        vstart,
  input  logic        vfire,
  input  logic        rd_done,
  input  logic [3:0]  ram_we,
  input  logic [39:0] rd_word_o
);
  assert_launch_enabled_R4: assert property (@(posedge clk) disable iff (!rst_s)
    launch |-> ctrl_i[8]);

  assert_launch_onehot_R5: assert property (@(posedge clk) disable iff (!rst_s)
    launch |-> ($countones(ctrl_i[7:0]) == 1));

  assert_launch_once_R6: assert property (@(posedge clk) disable iff (!rst_s)
    launch |=> (!$stable(ctrl_i) || !launch));

  assert_vstart_busy_R8: assert property (@(posedge clk) disable iff (!rst_s)
    vstart |=> busy);

  assert_vfire_idle_R8: assert property (@(posedge clk) disable iff (!rst_s)
    vfire |=> !busy);

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_s)
    busy |-> !launch);

  assert_single_we_R10: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(ram_we));

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_s)
    !rd_done |=> $stable(rd_word_o));
endmodule

bind mram_indirect_ctrl mram_ctrl_chk u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .ctrl_i    (ctrl_i),
  .launch    (launch),
  .busy      (busy),
  .vstart    (vstart),
  .vfire     (vfire),
  .rd_done   (rd_done),
  .ram_we    (ram_we),
  .rd_word_o (rd_word_o)
);

// File: tb/sim_mram_indirect_ctrl.sv
module sim_mram_indirect_ctrl;
  localparam int DEPTH = 256;
  localparam int VLAT  = 4;

  logic        clk;
  logic        rst_n;
  logic [9:0]  ram_addr_i;
  logic [39:0] wr_word_i;
  logic [8:0]  ctrl_i;
  logic [39:0] rd_word_o;

  int    checks;
  int    errs;
  bit    done;
  string cur_tag;

  mram_indirect_ctrl #(.ADDR_W(10), .DEPTH(DEPTH), .VLAT(VLAT)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .ram_addr_i (ram_addr_i),
    .wr_word_i  (wr_word_i),
    .ctrl_i     (ctrl_i),
    .rd_word_o  (rd_word_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference model
  logic [39:0] m_mem [4][DEPTH];
  logic [39:0] exp_rd;
  logic [7:0]  m_prev;
  int          m_cnt;
  int          m_id;
  bit          m_wr;
  int          v_addr;
  logic [39:0] v_word;
  bit          v_wr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_rd = '0;
      m_prev = '0;
      m_cnt  = 0;
    end else begin
      if (m_cnt != 0) begin
        if (m_cnt == 1) begin
          if (v_wr) m_mem[3][v_addr] = v_word;
          else      exp_rd = m_mem[3][v_addr];
        end
        m_cnt = m_cnt - 1;
      end else if (ctrl_i[8] && $countones(ctrl_i[7:0]) == 1 &&
                   (ctrl_i[7:0] & ~m_prev) != 8'h00) begin
        m_wr = (ctrl_i[3:0] != 4'h0);
        m_id = 0;
        for (int i = 0; i < 4; i++)
          if ((m_wr ? ctrl_i[i] : ctrl_i[i+4]) == 1'b1) m_id = i;
        if (m_id == 3) begin
          v_wr   = m_wr;
          v_addr = ram_addr_i % DEPTH;
          v_word = wr_word_i;
          m_cnt  = VLAT;
        end else if (m_wr) begin
          m_mem[m_id][ram_addr_i % DEPTH] = wr_word_i;
        end else begin
          exp_rd = m_mem[m_id][ram_addr_i % DEPTH];
        end
      end
      m_prev = ctrl_i[7:0];
    end
  end

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) check(cur_tag, rd_word_o, exp_rd);
  end

  task automatic step(input logic [8:0] c);
    @(negedge clk);
    ctrl_i <= c;
  endtask

  task automatic access(input int ram, input bit wr, input logic [9:0] a, input logic [39:0] w);
    logic [8:0] opb;
    opb = 9'h100 | (9'h001 << (ram + (wr ? 0 : 4)));
    @(negedge clk);
    ram_addr_i <= a;
    wr_word_i  <= w;
    ctrl_i     <= 9'h100;
    step(opb);
    step(9'h100);
    step(9'h000);
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [39:0] pack(input int f3, input int f2, input int f1, input int f0);
    return {f3[9:0], f2[9:0], f1[9:0], f0[9:0]};
  endfunction

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks = 0; errs = 0; done = 1'b0; cur_tag = "R1";
    rst_n = 1'b0; ram_addr_i = '0; wr_word_i = '0; ctrl_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset value", rd_word_o, 40'h0);

    // R2 R3 R10: distinct words at one address in C, E, H
    cur_tag = "R2/R3/R10";
    access(0, 1, 10'd5, pack(1, 2, 3, 4));
    access(1, 1, 10'd5, pack(10'h3FF, 0, 10'h155, 10'h2AA));
    access(2, 1, 10'd5, pack(7, 8, 9, 10'h200));
    access(1, 0, 10'd5, 40'h0);
    check("R3 E read", rd_word_o, pack(10'h3FF, 0, 10'h155, 10'h2AA));
    access(0, 0, 10'd5, 40'h0);
    check("R2 C field order", rd_word_o, pack(1, 2, 3, 4));
    access(2, 0, 10'd5, 40'h0);
    check("R10 H separate", rd_word_o, pack(7, 8, 9, 10'h200));

    // R7: fast read visible right after the accepting edge
    cur_tag = "R7";
    @(negedge clk); ram_addr_i <= 10'd5; ctrl_i <= 9'h100;
    step(9'h110);
    @(negedge clk);
    check("R7 fast read latency", rd_word_o, pack(1, 2, 3, 4));
    step(9'h100); step(9'h000);

    // R8: vector write then read, cycle exact
    cur_tag = "R8";
    access(3, 1, 10'd7, pack(11, 22, 33, 44));
    @(negedge clk); ram_addr_i <= 10'd7; ctrl_i <= 9'h100;
    step(9'h180);
    @(negedge clk); ram_addr_i <= 10'd5;   // latched address must be used
    repeat (VLAT - 1) @(negedge clk);
    check("R8 before completion", rd_word_o, pack(1, 2, 3, 4));
    @(negedge clk);
    check("R8 at completion", rd_word_o, pack(11, 22, 33, 44));
    step(9'h100); step(9'h000);
    repeat (4) @(negedge clk);

    // R9: request during vector access is ignored
    cur_tag = "R9";
    @(negedge clk); ram_addr_i <= 10'd7; ctrl_i <= 9'h100;
    step(9'h180);
    @(negedge clk); ram_addr_i <= 10'd5; wr_word_i <= pack(0, 0, 0, 1); ctrl_i <= 9'h101;
    step(9'h100); step(9'h000);
    repeat (6) @(negedge clk);
    access(0, 0, 10'd5, 40'h0);
    check("R9 C unchanged", rd_word_o, pack(1, 2, 3, 4));

    // R4: no enable
    cur_tag = "R4";
    @(negedge clk); ram_addr_i <= 10'd5; wr_word_i <= pack(5, 5, 5, 5);
    step(9'h001); step(9'h010); step(9'h000);
    repeat (2) @(negedge clk);
    check("R4 no read without enable", rd_word_o, pack(1, 2, 3, 4));
    access(0, 0, 10'd5, 40'h0);
    check("R4 C unchanged", rd_word_o, pack(1, 2, 3, 4));

    // R5: several op bits
    cur_tag = "R5";
    @(negedge clk); ram_addr_i <= 10'd5; wr_word_i <= pack(6, 6, 6, 6); ctrl_i <= 9'h100;
    step(9'h103); step(9'h100); step(9'h121); step(9'h100); step(9'h000);
    repeat (2) @(negedge clk);
    access(1, 0, 10'd5, 40'h0);
    check("R5 E unchanged", rd_word_o, pack(10'h3FF, 0, 10'h155, 10'h2AA));
    access(0, 0, 10'd5, 40'h0);
    check("R5 C unchanged", rd_word_o, pack(1, 2, 3, 4));

    // R6: held write bit with changing data; held read bit with changing address
    cur_tag = "R6";
    @(negedge clk); ram_addr_i <= 10'd9; wr_word_i <= pack(1, 1, 1, 1); ctrl_i <= 9'h100;
    step(9'h104);
    @(negedge clk); wr_word_i <= pack(2, 2, 2, 2);
    @(negedge clk); ram_addr_i <= 10'd10;
    step(9'h100); step(9'h000);
    repeat (2) @(negedge clk);
    access(2, 0, 10'd9, 40'h0);
    check("R6 single write", rd_word_o, pack(1, 1, 1, 1));
    @(negedge clk); ctrl_i <= 9'h100;
    step(9'h140);
    @(negedge clk); ram_addr_i <= 10'd5;
    @(negedge clk);
    check("R6 held read no repeat", rd_word_o, pack(1, 1, 1, 1));
    step(9'h100); step(9'h000);

    // R11: aliasing above DEPTH
    cur_tag = "R11";
    access(1, 1, 10'd3, pack(3, 1, 4, 1));
    access(1, 0, 10'd3 + 10'(DEPTH), 40'h0);
    check("R11 alias read", rd_word_o, pack(3, 1, 4, 1));

    // R12: writes leave read-back untouched
    cur_tag = "R12";
    access(3, 1, 10'd300, pack(9, 9, 9, 9));
    access(0, 1, 10'd6, pack(8, 8, 8, 8));
    check("R12 hold after writes", rd_word_o, pack(3, 1, 4, 1));
    access(3, 0, 10'd44, 40'h0);
    check("R12 vector alias read", rd_word_o, pack(9, 9, 9, 9));

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule